// File: doc/BRIEF.md
# Leading/Trailing Zero Counter

This block counts the zero bits that stand below the lowest set bit (trailing) or above the highest set bit (leading) of a 64-bit operand. A width select limits the count to the low 32-bit word. The caller presents an operand, a direction and a width together with a one-cycle start strobe. A 7-bit count and a one-cycle valid strobe appear two clock cycles later.

The datapath has no priority encoder. It isolates the least-significant set bit with `x & -x`, which leaves a one-hot vector. One OR reduction per index bit then turns that vector into a binary position. For a leading count the operand is bit-reversed first, over all 64 bits or over the low word only, so both directions use the same isolate-and-encode path. The two pipeline stages register on every cycle, so a new start can be issued on each clock.

Top module: `zcnt_unit`

## Requirements
- R1: With lead_i=0 and width32_i=0, count_o equals the number of zero bits below the least-significant set bit of the 64-bit operand.
- R2: With lead_i=1 and width32_i=0, count_o equals the number of zero bits above the most-significant set bit of the 64-bit operand.
- R3: An all-zero operand with width32_i=0 yields count_o = 64 in either direction.
- R4: With width32_i=1 and lead_i=0, operand bits 63:32 have no effect and the trailing count is taken over bits 31:0 only.
- R5: With width32_i=1 and lead_i=1, the leading count starts at bit 31, and bits 63:32 have no effect.
- R6: With width32_i=1, an operand whose bits 31:0 are all zero yields count_o = 32 in either direction.
- R7: valid_o is high for exactly one cycle, in the second cycle after the clock edge that samples start_i high. Without a start it stays low. After reset, valid_o and count_o are 0.
- R8: Starts on consecutive cycles each produce their own result, on consecutive cycles and in issue order.
- R9: count_o holds its last result while valid_o is low. Operand, direction or width changes made without a start do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; samples operand and mode |
| operand_i | input | 64 | Value to examine |
| lead_i | input | 1 | 1 = leading-zero count, 0 = trailing-zero count |
| width32_i | input | 1 | 1 = examine bits 31:0 only |
| valid_o | output | 1 | One-cycle result strobe |
| count_o | output | 7 | Zero count, 0 to 64 |

## Verification
On every cycle the assertions check the two-cycle latency of the strobe in both directions, the range of the count, the fixed results for an all-zero operand in each width, and that the count holds between results. Only the bench scenarios can show that the count is correct for arbitrary operands. The same holds for the reversal in each width, the masking of the upper word in 32-bit mode, and the ordering of back-to-back results. These are compared against a bit-scan model in the bench.

// File: rtl/zcnt_pkg.sv
package zcnt_pkg;
  typedef enum logic {
    DIR_TRAIL = 1'b0,
    DIR_LEAD  = 1'b1
  } zdir_e;

  typedef struct packed {
    logic vld;
    logic half;
    logic zero;
  } zctl_s;
endpackage

// File: rtl/zcnt_prep.sv
module zcnt_prep #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              lead_i,
  input  logic              half_i,
  output logic [DATA_W-1:0] prep_o
);
  import zcnt_pkg::*;
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] rev_full;
  logic [DATA_W-1:0] rev_half;
  logic [DATA_W-1:0] low_only;
  zdir_e             dir;

  assign dir = zdir_e'(lead_i);

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev_full
    assign rev_full[i] = data_i[DATA_W-1-i];
  end

  for (genvar i = 0; i < HALF_W; i++) begin : g_rev_half
    assign rev_half[i] = data_i[HALF_W-1-i];
  end
  assign rev_half[DATA_W-1:HALF_W] = '0;

  assign low_only = {{HALF_W{1'b0}}, data_i[HALF_W-1:0]};

  always_comb begin
    unique case ({half_i, dir == DIR_LEAD})
      2'b00:   prep_o = data_i;
      2'b01:   prep_o = rev_full;
      2'b10:   prep_o = low_only;
      default: prep_o = rev_half;
    endcase
  end
endmodule

// File: rtl/zcnt_isolate.sv
module zcnt_isolate #(
  parameter int DATA_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic               half_i,
  input  logic [DATA_W-1:0]  x_i,
  output logic [DATA_W-1:0]  onehot_o,
  output zcnt_pkg::zctl_s    ctl_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] neg_x;
  logic [DATA_W-1:0] lowest;

  assign neg_x  = ~x_i + ONE;
  assign lowest = x_i & neg_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      onehot_o <= '0;
      ctl_o    <= '0;
    end else begin
      onehot_o   <= lowest;
      ctl_o.vld  <= vld_i;
      ctl_o.half <= half_i;
      ctl_o.zero <= ~|x_i;
    end
  end
endmodule

// File: rtl/zcnt_encode.sv
module zcnt_encode #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = $clog2(DATA_W),
  parameter int CNT_W  = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] onehot_i,
  input  zcnt_pkg::zctl_s   ctl_i,
  output logic              vld_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] bit_mask(input int k);
    logic [DATA_W-1:0] m;
    for (int j = 0; j < DATA_W; j++) m[j] = ((j >> k) & 1) != 0;
    return m;
  endfunction

  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt_d;

  // one OR tree per index bit
  for (genvar k = 0; k < IDX_W; k++) begin : g_or_tree
    localparam logic [DATA_W-1:0] MASK = bit_mask(k);
    assign idx[k] = |(onehot_i & MASK);
  end

  always_comb begin
    if (ctl_i.zero) cnt_d = ctl_i.half ? CNT_W'(HALF_W) : CNT_W'(DATA_W);
    else            cnt_d = {1'b0, idx};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      cnt_o <= '0;
    end else begin
      vld_o <= ctl_i.vld;
      if (ctl_i.vld) cnt_o <= cnt_d;
    end
  end
endmodule

// File: rtl/zcnt_unit.sv
module zcnt_unit #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              lead_i,
  input  logic              width32_i,
  output logic              valid_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam int IDX_W = CNT_W - 1;

  logic [DATA_W-1:0] prep;
  logic [DATA_W-1:0] onehot_q;
  zcnt_pkg::zctl_s   ctl_q;

  zcnt_prep #(.DATA_W(DATA_W)) u_prep (
    .data_i (operand_i),
    .lead_i (lead_i),
    .half_i (width32_i),
    .prep_o (prep)
  );

  zcnt_isolate #(.DATA_W(DATA_W)) u_iso (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (start_i),
    .half_i   (width32_i),
    .x_i      (prep),
    .onehot_o (onehot_q),
    .ctl_o    (ctl_q)
  );

  zcnt_encode #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_enc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .onehot_i (onehot_q),
    .ctl_i    (ctl_q),
    .vld_o    (valid_o),
    .cnt_o    (count_o)
  );
endmodule

// File: rtl/zcnt_unit_chk.sv
module zcnt_unit_chk #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = $clog2(DATA_W) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [DATA_W-1:0] operand_i,
  input logic              lead_i,
  input logic              width32_i,
  input logic              valid_o,
  input logic [CNT_W-1:0]  count_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [1:0] age;
  logic       zero_full;
  logic       zero_half;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assign zero_full = start_i && !width32_i && (operand_i == '0);
  assign zero_half = start_i && width32_i && (operand_i[HALF_W-1:0] == '0);

  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ##1 valid_o);

  a_r7_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && age >= 2'd2) |-> $past(start_i, 2));

  a_r1_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (count_o <= CNT_W'(DATA_W)));

  a_r3_zero_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && age >= 2'd2 && $past(zero_full, 2)) |-> (count_o == CNT_W'(DATA_W)));

  a_r6_zero_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && age >= 2'd2 && $past(zero_half, 2)) |-> (count_o == CNT_W'(HALF_W)));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && age >= 2'd1) |-> $stable(count_o));

  // lead_i only shapes the datapath; referenced to keep the port list complete
  logic unused_lead;
  assign unused_lead = lead_i;
endmodule

bind zcnt_unit zcnt_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .operand_i (operand_i),
  .lead_i    (lead_i),
  .width32_i (width32_i),
  .valid_o   (valid_o),
  .count_o   (count_o)
);

// File: tb/zcnt_unit_test.sv
module zcnt_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic        lead_i = 1'b0;
  logic        width32_i = 1'b0;
  logic        valid_o;
  logic [6:0]  count_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  zcnt_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .operand_i(operand_i),
    .lead_i(lead_i), .width32_i(width32_i), .valid_o(valid_o), .count_o(count_o)
  );

  function automatic int ref_cnt(logic [63:0] x, bit lead, bit half);
    int w = half ? 32 : 64;
    int n = 0;
    for (int i = 0; i < w; i++) begin
      int b = lead ? (w - 1 - i) : i;
      if (x[b]) return n;
      n++;
    end
    return n;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic [63:0] x, bit lead, bit half);
    start_i = 1'b1; operand_i = x; lead_i = lead; width32_i = half;
  endtask

  // single op: start at a negedge, result visible two negedges later
  task automatic run_one(string req, logic [63:0] x, bit lead, bit half);
    @(negedge clk); drive(x, lead, half);
    @(negedge clk); start_i = 1'b0;
    check({req, " valid early"}, valid_o, 0);
    @(negedge clk);
    check({req, " valid"}, valid_o, 1);
    check(req, count_o, ref_cnt(x, lead, half));
    @(negedge clk);
    check({req, " valid one cycle (R7)"}, valid_o, 0);
  endtask

  task automatic t_reset;
    check("R7 reset valid", valid_o, 0);
    check("R7 reset count", count_o, 0);
  endtask

  task automatic t_r1_trailing;
    run_one("R1", 64'h0000_0000_0000_0001, 0, 0);
    run_one("R1", 64'h8000_0000_0000_0000, 0, 0);
    run_one("R1", 64'h0000_0100_0000_0000, 0, 0);
    run_one("R1", 64'hFFFF_FFFF_FFFF_FFF0, 0, 0);
  endtask

  task automatic t_r2_leading;
    run_one("R2", 64'h8000_0000_0000_0000, 1, 0);
    run_one("R2", 64'h0000_0000_0000_0001, 1, 0);
    run_one("R2", 64'h0000_0F00_0000_0123, 1, 0);
  endtask

  task automatic t_r3_zero;
    run_one("R3", 64'h0, 0, 0);
    run_one("R3", 64'h0, 1, 0);
  endtask

  task automatic t_r4_half_trailing;
    run_one("R4", 64'hFFFF_FFFF_0000_0800, 0, 1);
    run_one("R4", 64'h0000_0001_8000_0000, 0, 1);
  endtask

  task automatic t_r5_half_leading;
    run_one("R5", 64'hFFFF_FFFF_0000_0001, 1, 1);
    run_one("R5", 64'h1234_5678_0040_0000, 1, 1);
    run_one("R5", 64'h0000_0000_8000_0000, 1, 1);
  endtask

  task automatic t_r6_half_zero;
    run_one("R6", 64'hFFFF_FFFF_0000_0000, 0, 1);
    run_one("R6", 64'h8000_0001_0000_0000, 1, 1);
  endtask

  task automatic t_r8_back_to_back;
    logic [63:0] a = 64'h0000_0000_0000_0010;
    logic [63:0] b = 64'h0001_0000_0000_0000;
    logic [63:0] c = 64'hFFFF_FFFF_0000_0000;
    @(negedge clk); drive(a, 0, 0);
    @(negedge clk); drive(b, 1, 0);
    @(negedge clk);
    check("R8 first", count_o, ref_cnt(a, 0, 0));
    check("R8 first valid", valid_o, 1);
    drive(c, 0, 1);
    @(negedge clk); start_i = 1'b0;
    check("R8 second", count_o, ref_cnt(b, 1, 0));
    check("R8 second valid", valid_o, 1);
    @(negedge clk);
    check("R8 third", count_o, ref_cnt(c, 0, 1));
    check("R8 third valid", valid_o, 1);
    @(negedge clk);
    check("R8 end valid", valid_o, 0);
  endtask

  task automatic t_r9_hold;
    int last;
    run_one("R9 setup", 64'h0000_0000_0000_0100, 0, 0);
    last = count_o;
    operand_i = 64'h1; lead_i = 1'b1; width32_i = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 hold count", count_o, last);
    check("R9 hold valid", valid_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset;
    t_r1_trailing;
    t_r2_leading;
    t_r3_zero;
    t_r4_half_trailing;
    t_r5_half_leading;
    t_r6_half_zero;
    t_r8_back_to_back;
    t_r9_hold;
    done = 1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule